// File: doc/BRIEF.md
# Prescaled Timer with Compare-Clear Mode

This block is a 16-bit up-counting timer driven from the system clock through a selectable prescaler. Software programs it over a small register bus: it picks a divide ratio, chooses between free-running wrap mode and compare-clear mode, loads the counter, sets the compare value, and masks or clears interrupt flags. A single level interrupt line is the OR of the pending flags whose enables are set.

In free-running mode the counter rolls over from all ones to zero and raises an overflow flag. Presetting the counter shortens the first period. In compare-clear mode the hardware sends the counter back to zero on the tick that finds it equal to the compare register. This gives a fixed period of compare-plus-one ticks. The counting hardware is then the only agent that ever modifies the counter, so a periodic tick never needs the racy read-subtract-write sequence in software that drops ticks.

Top module: `tick_timer`

## Requirements
- R1: After reset every register (control, counter, compare, mask, flags) reads zero and `irq` is low.
- R2: Control bits [2:0] select the tick rate: code 1 gives every clock, 2 gives one in 8, 3 one in 64, 4 one in 256, 5 one in 1024; codes 0, 6 and 7 stop the counter. A control write that changes this code restarts the prescaler phase, so the first increment comes exactly one full divide period after the write edge.
- R3: With control bit 3 at 0 (free-running), each tick adds one to the counter, and the tick that moves it from 0xFFFF to 0x0000 sets the overflow flag (flags bit 0).
- R4: With control bit 3 at 1 (compare-clear), a tick that finds the counter equal to the compare register loads zero instead of incrementing, giving a period of compare+1 ticks. In either mode such a tick sets the match flag (flags bit 1). A compare-clear is never counted as an overflow.
- R5: `irq` is high exactly while some flag bit is set and its enable in the mask register is set (mask bit 0 enables overflow, bit 1 enables match).
- R6: Writing 0x10000−N to the counter in free-running mode makes the overflow flag rise on the N-th following tick and not before.
- R7: A counter write in the same clock as a tick wins. The counter takes the written value, and the discarded tick raises no flag.
- R8: Writing the flags register clears each flag whose data bit is 1 and leaves the others. A set event in the same clock as its clear leaves the flag set.
- R9: Register addresses are 0 control, 1 counter, 2 compare, 3 mask, 4 flags. Read data follows the address combinationally, unused addresses read zero, and reads have no side effect.

Verification section follows the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt: any enabled pending flag |

## Verification
On every cycle the assertions check the following behaviours:
- a stopped clock code freezes the counter;
- each free-running tick adds one;
- the 0xFFFF rollover lands in the overflow flag;
- a compare-clear tick zeroes the counter and raises the match flag;
- a counter write overrides a coincident tick;
- a set event survives a coincident clear;
- an all-zero mask silences the interrupt.

Only the bench's scenarios can show the timing relations:
- that the first tick after a rate change arrives a full divide period later;
- that a preset of 0x10000−N overflows on exactly the N-th tick;
- that the compare-clear period holds at compare+1 over many cycles.

The bench also shows that a random mix of writes, mode changes and clears keeps every register and the interrupt line in agreement with an independent model.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // register addresses
  localparam int A_CTRL  = 0;
  localparam int A_COUNT = 1;
  localparam int A_CMP   = 2;
  localparam int A_MASK  = 3;
  localparam int A_FLAGS = 4;

  // flag / mask bit positions
  localparam int F_OVF = 0;
  localparam int F_MATCH = 1;

  // clock-select code to divide ratio; zero means stopped
  function automatic int unsigned div_for(input logic [2:0] code);
    case (code)
      3'd1:    return 1;
      3'd2:    return 8;
      3'd3:    return 64;
      3'd4:    return 256;
      3'd5:    return 1024;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PS_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cs,
  input  logic       restart,
  output logic       tick
);
  import timer_pkg::*;

  localparam int DW = PS_W + 1;

  logic [PS_W-1:0] phase_q;
  logic [DW-1:0]   div_w;

  assign div_w = DW'(div_for(cs));
  assign tick  = (div_w != '0) && ({1'b0, phase_q} == div_w - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                          phase_q <= '0;
    else if (restart || tick || div_w == '0) phase_q <= '0;
    else                                 phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctc,
  input  logic [CNT_W-1:0] cmp,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             cmp_evt
);
  logic hit, clr_hit, live;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                            input logic clr);
    return clr ? '0 : v + 1'b1;
  endfunction

  assign hit     = (cnt == cmp);
  assign clr_hit = ctc && hit;
  assign live    = tick && !wr_en;           // a software write swallows the tick
  assign cmp_evt = live && hit;
  assign ovf_evt = live && !clr_hit && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wdata;
    else if (tick)  cnt <= step(cnt, clr_hit);
  end
endmodule

// File: rtl/tick_flags.sv
module tick_flags #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_bits,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] clr_w;
  assign clr_w = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_w) | set_evt;   // set beats clear
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int PS_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  import timer_pkg::*;

  localparam int NF = 2;

  logic [2:0]       cs_q;
  logic             ctc_q;
  logic [CNT_W-1:0] cmp_q;
  logic [NF-1:0]    mask_q;
  logic [NF-1:0]    flags_q;
  logic [CNT_W-1:0] cnt_w;
  logic             tick_w, ovf_evt, cmp_evt;
  logic             ctrl_wr, cnt_wr, cmp_wr, mask_wr, flag_wr, ps_restart;

  assign ctrl_wr    = bus_we && (bus_addr == ADDR_W'(A_CTRL));
  assign cnt_wr     = bus_we && (bus_addr == ADDR_W'(A_COUNT));
  assign cmp_wr     = bus_we && (bus_addr == ADDR_W'(A_CMP));
  assign mask_wr    = bus_we && (bus_addr == ADDR_W'(A_MASK));
  assign flag_wr    = bus_we && (bus_addr == ADDR_W'(A_FLAGS));
  assign ps_restart = ctrl_wr && (bus_wdata[2:0] != cs_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= '0;
      ctc_q  <= 1'b0;
      cmp_q  <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_wr) begin
        cs_q  <= bus_wdata[2:0];
        ctc_q <= bus_wdata[3];
      end
      if (cmp_wr)  cmp_q  <= bus_wdata;
      if (mask_wr) mask_q <= bus_wdata[NF-1:0];
    end
  end

  tick_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .cs(cs_q), .restart(ps_restart), .tick(tick_w)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .ctc(ctc_q), .cmp(cmp_q),
    .wr_en(cnt_wr), .wdata(bus_wdata), .cnt(cnt_w),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );

  tick_flags #(.NF(NF)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_evt({cmp_evt, ovf_evt}),
    .clr_wr(flag_wr), .clr_bits(bus_wdata[NF-1:0]), .flags(flags_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      A_CTRL:  bus_rdata = CNT_W'({ctc_q, cs_q});
      A_COUNT: bus_rdata = cnt_w;
      A_CMP:   bus_rdata = cmp_q;
      A_MASK:  bus_rdata = CNT_W'(mask_q);
      A_FLAGS: bus_rdata = CNT_W'(flags_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |(flags_q & mask_q);
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cs,
  input logic             ctc,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wdata,
  input logic             ovf_evt,
  input logic             cmp_evt,
  input logic [1:0]       flags,
  input logic [1:0]       mask,
  input logic             irq
);
  // stopped codes freeze the counter
  p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 3'd0 && !cnt_wr) |=> $stable(cnt));

  // free-running tick adds one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctc && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

  // rollover lands in the overflow flag
  p_wrap_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == '1 && !(ctc && cnt == cmp)) |=> flags[0]);

  // compare-clear zeroes counter and raises match
  p_ctc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctc && !cnt_wr && cnt == cmp) |=> (cnt == '0 && flags[1]));

  // nothing pending-and-enabled when mask is empty
  p_mask_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq);

  // software write beats a coincident tick
  p_sw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata)));

  // set events survive a coincident clear
  p_set_beats_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[0]);
  p_match_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> flags[1]);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs_q), .ctc(ctc_q), .tick(tick_w),
  .cnt(cnt_w), .cmp(cmp_q), .cnt_wr(cnt_wr), .wdata(bus_wdata),
  .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .flags(flags_q), .mask(mask_q),
  .irq(irq)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- reference model, written from the requirements ----------
  logic [2:0]  m_cs;
  logic        m_ctc;
  logic [15:0] m_cnt, m_cmp;
  logic [1:0]  m_mask, m_flags;
  int          m_phase;

  function automatic int mdiv(input logic [2:0] c);  // R2 rate table
    if (c == 3'd1) return 1;
    if (c == 3'd2) return 8;
    if (c == 3'd3) return 64;
    if (c == 3'd4) return 256;
    if (c == 3'd5) return 1024;
    return 0;
  endfunction

  function automatic logic [15:0] mread(input int a);  // R9 map
    case (a)
      0: return {12'h0, m_ctc, m_cs};
      1: return m_cnt;
      2: return m_cmp;
      3: return {14'h0, m_mask};
      4: return {14'h0, m_flags};
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int d;
    bit tk, wc;
    logic [1:0] ev;
    logic [15:0] ncnt;
    if (!rst_n) begin
      m_cs = 0; m_ctc = 0; m_cnt = 0; m_cmp = 0; m_mask = 0; m_flags = 0; m_phase = 0;
    end else begin
      d  = mdiv(m_cs);
      tk = (d != 0) && (m_phase == d - 1);
      wc = bus_we && bus_addr == 3'd1;
      ev = 2'b00;
      ncnt = m_cnt;
      if (wc) ncnt = bus_wdata;
      else if (tk) begin
        if (m_cnt == m_cmp) ev[1] = 1'b1;
        if (m_ctc && m_cnt == m_cmp) ncnt = 16'h0;
        else begin
          if (m_cnt == 16'hFFFF) ev[0] = 1'b1;
          ncnt = m_cnt + 16'h1;
        end
      end
      if (bus_we && bus_addr == 3'd0 && bus_wdata[2:0] != m_cs) m_phase = 0;
      else if (d == 0 || tk) m_phase = 0;
      else m_phase = m_phase + 1;
      if (bus_we && bus_addr == 3'd4) m_flags = (m_flags & ~bus_wdata[1:0]) | ev;
      else m_flags = m_flags | ev;
      if (bus_we && bus_addr == 3'd0) begin m_cs = bus_wdata[2:0]; m_ctc = bus_wdata[3]; end
      if (bus_we && bus_addr == 3'd2) m_cmp = bus_wdata;
      if (bus_we && bus_addr == 3'd3) m_mask = bus_wdata[1:0];
      m_cnt = ncnt;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    bus_addr = a[2:0];
    #1;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin : main
    logic [15:0] v;
    void'($urandom(32'h5EED_7131));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R1 reset reg", v, 16'h0); end
    chk("R1 irq low", {15'h0, irq}, 16'h0);

    // R9 map and readback while stopped
    wr(2, 16'hA5C3); wr(3, 16'h0003); wr(0, 16'h0008);
    rd(2, v); chk("R9 compare readback", v, 16'hA5C3);
    rd(3, v); chk("R9 mask readback", v, 16'h0003);
    rd(0, v); chk("R9 control readback", v, 16'h0008);
    rd(6, v); chk("R9 unused address", v, 16'h0);
    wr(0, 16'h0000);

    // R2 stop code keeps counter still, then /8 first tick after a full period
    wr(1, 16'h0000);
    idle(10); rd(1, v); chk("R2 stopped counter", v, 16'h0);
    wr(0, 16'h0002);
    idle(7); rd(1, v); chk("R2 /8 before first tick", v, 16'h0);
    idle(1); rd(1, v); chk("R2 /8 first tick", v, 16'h1);
    idle(8); rd(1, v); chk("R2 /8 second tick", v, 16'h2);
    wr(0, 16'h0003);
    idle(63); rd(1, v); chk("R2 /64 before first tick", v, 16'h2);
    idle(1); rd(1, v); chk("R2 /64 first tick", v, 16'h3);

    // R6 preset 0x10000-3 at full rate
    wr(0, 16'h0001);
    wr(4, 16'h0003);
    wr(1, 16'hFFFD);
    idle(2); rd(4, v); chk("R6 no overflow before third tick", v & 16'h1, 16'h0);
    idle(1); rd(4, v); chk("R6 overflow on third tick", v & 16'h1, 16'h1);
    rd(1, v); chk("R3 wrapped to zero", v, 16'h0);
    chk("R5 irq with overflow enabled", {15'h0, irq}, 16'h1);
    wr(3, 16'h0002);
    chk("R5 irq masked off", {15'h0, irq}, 16'h0);

    // R8 clear, and set beating a coincident clear
    wr(4, 16'h0003);
    rd(4, v); chk("R8 write-one clears", v, 16'h0);
    wr(1, 16'hFFFE);
    wr(4, 16'h0001);            // lands on the rollover edge
    rd(4, v); chk("R8 set wins over clear", v & 16'h1, 16'h1);
    wr(4, 16'h0000);
    rd(4, v); chk("R8 zero write leaves flag", v & 16'h1, 16'h1);
    wr(4, 16'h0001);
    rd(4, v); chk("R8 clear on quiet cycle", v & 16'h1, 16'h0);

    // R7 write beats coincident tick
    wr(1, 16'h1234);
    rd(1, v); chk("R7 written value kept", v, 16'h1234);
    idle(1); rd(1, v); chk("R7 counting resumes", v, 16'h1235);

    // R4 compare-clear with compare=3, period 4
    wr(0, 16'h0009); wr(2, 16'h0003); wr(4, 16'h0003); wr(1, 16'h0000);
    idle(3); rd(1, v); chk("R4 reaches compare", v, 16'h3);
    rd(4, v); chk("R4 no match yet", v & 16'h2, 16'h0);
    idle(1); rd(1, v); chk("R4 cleared to zero", v, 16'h0);
    rd(4, v); chk("R4 match flag", v, 16'h2);
    idle(4); rd(1, v); chk("R4 period compare+1", v, 16'h0);

    // random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      int op, a;
      logic [15:0] d;
      op = $urandom % 8;
      if (op < 5) begin
        a = op;
        case (a)
          0: begin
            int k; k = $urandom % 6;
            d = {12'h0, 1'($urandom % 2), (k < 3) ? 3'd1 : (k == 3) ? 3'd2 : (k == 4) ? 3'd3 : 3'd0};
          end
          1: d = ($urandom % 2) ? (16'hFFF0 + 16'($urandom % 16)) : 16'($urandom % 24);
          2: d = 16'($urandom % 20);
          default: d = 16'($urandom % 4);
        endcase
        wr(a, d);
      end else idle($urandom % 4);
      a = $urandom % 6;
      rd(a, v);
      chk($sformatf("R9 random read addr %0d (R3 R4 R7 R8)", a), v, mread(a));
      chk("R5 random irq", {15'h0, irq}, {15'h0, |(m_flags & m_mask)});
    end

    summary();
  end
endmodule